// File: doc/BRIEF.md
# Drift-Time Hit Classifier

This block looks at the hit pulses from the twelve sense wires of one drift-chamber cell. It tags each wire according to when its hits arrived after a bunch crossing. A free-running tick counter restarts at zero on every crossing strobe. Each clock cycle, the current tick is compared against two programmable edges, which split the drift time into an early ("prompt") window and a later ("delayed") window. Any hit on a wire during a window sets that wire's flag for that window. The two flags are independent, so one wire can carry both labels in the same crossing.

On the next crossing strobe, the flags gathered since the previous strobe move into an output register. The output register raises a one-cycle valid pulse. The flags then start again from empty. Hits that arrive after the delayed window has closed leave no trace. A downstream segment finder reads one 24-bit word per cell per crossing. With a 3 ns tick, the defaults place the window boundary at 22 ticks and the end of the delayed window at 70 ticks.

Top module: `drift_hit_classifier`

## Requirements
- R1: While `rst` is high at a clock edge, and after that edge, `word_out` is zero and `word_valid` is low.
- R2: Tick numbering works as follows. The cycle in which `xing_strobe` is high has tick 0, and each later cycle adds one. A hit on wire i in a cycle whose tick is below `prompt_end` sets the prompt flag of wire i.
- R3: A hit on wire i in a cycle whose tick is at least `prompt_end` and below `delayed_end` sets the delayed flag of wire i. A tick equal to `prompt_end` is delayed, not prompt.
- R4: Some hits are ignored:
  - a hit at a tick of `delayed_end` or more;
  - a hit before the first strobe after reset, because the tick then rests at its maximum value 2^TICK_W-1 and saturates there.
- R5: The prompt and delayed flags of a wire are independent, so both can be set in one crossing period. Wires do not affect each other. Within a period a flag, once set, stays set.
- R6: In the cycle after each strobe, `word_valid` is high for exactly one cycle. `word_out` then carries the flags from the strobe cycle up to, but not including, the new strobe cycle:
  - bit i holds the prompt flag of wire i;
  - bit 12+i holds the delayed flag of wire i.
- R7: A strobe clears all flags for the new period. Hits in the strobe cycle itself count at tick 0 of the new period and do not appear in the word emitted for the closing period.
- R8: `word_out` holds its value in every cycle in which `word_valid` is low.
- R9: `prompt_end` and `delayed_end` are read every cycle. Changing them moves the window edges for the hits that follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| xing_strobe | input | 1 | Bunch-crossing strobe, marks tick 0 |
| hit_in | input | 12 | Hit pulse per sense wire |
| prompt_end | input | 8 | First tick that is no longer prompt |
| delayed_end | input | 8 | First tick after the delayed window |
| word_out | output | 24 | Prompt flags [11:0], delayed flags [23:12] |
| word_valid | output | 1 | One-cycle pulse after each strobe |

## Verification
On every cycle, the embedded assertions check several rules:
- the flags never change while the tick is outside the windows;
- no prompt flag appears once the prompt window has passed;
- flags never clear in the middle of a period;
- a strobe with no hits empties them;
- the valid pulse only follows a strobe;
- the output word holds between pulses.

Only the bench scenarios can show that the exact boundary ticks land in the right window and that strobe-cycle hits go to the new period. They also confirm that hits before the first strobe are dropped, that reprogrammed edges take effect, and that the emitted word matches the hits of each whole period.

// File: rtl/dhc_pkg.sv
package dhc_pkg;

    localparam int unsigned NUM_WIRES = 12;
    localparam int unsigned TICK_W    = 8;

    typedef enum logic [1:0] {
        WIN_NONE    = 2'd0,
        WIN_PROMPT  = 2'd1,
        WIN_DELAYED = 2'd2
    } win_t;

    // Window lookup for one tick; edges are exclusive upper bounds.
    function automatic win_t classify_tick(input int unsigned tick,
                                           input int unsigned p_end,
                                           input int unsigned d_end);
        if (tick < p_end)
            return WIN_PROMPT;
        else if (tick < d_end)
            return WIN_DELAYED;
        else
            return WIN_NONE;
    endfunction

endpackage

// File: rtl/dhc_tick_counter.sv
module dhc_tick_counter #(
    parameter int unsigned TICK_W = dhc_pkg::TICK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    output logic [TICK_W-1:0] tick_now
);

    localparam logic [TICK_W-1:0] TICK_MAX = {TICK_W{1'b1}};

    logic [TICK_W-1:0] tick_q;

    always_comb begin
        if (strobe)
            tick_now = '0;
        else if (tick_q == TICK_MAX)
            tick_now = TICK_MAX;
        else
            tick_now = tick_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            tick_q <= TICK_MAX;
        else
            tick_q <= tick_now;
    end

    // R4: once saturated, the count stays parked until a strobe
    assert_tick_parked_R4: assert property (@(posedge clk) disable iff (rst)
        (tick_q == TICK_MAX && !strobe) |=> (tick_q == TICK_MAX));

endmodule

// File: rtl/dhc_wire_flags.sv
module dhc_wire_flags
    import dhc_pkg::*;
#(
    parameter int unsigned NUM_WIRES = dhc_pkg::NUM_WIRES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 strobe,
    input  logic [NUM_WIRES-1:0] hits,
    input  win_t                 win,
    output logic [NUM_WIRES-1:0] prompt_q,
    output logic [NUM_WIRES-1:0] delayed_q
);

    logic in_prompt;
    logic in_delayed;

    assign in_prompt  = (win == WIN_PROMPT);
    assign in_delayed = (win == WIN_DELAYED);

    for (genvar w = 0; w < NUM_WIRES; w++) begin : g_wire
        logic p_bit;
        logic d_bit;

        always_ff @(posedge clk) begin
            if (rst) begin
                p_bit <= 1'b0;
                d_bit <= 1'b0;
            end else begin
                p_bit <= (p_bit & ~strobe) | (hits[w] & in_prompt);
                d_bit <= (d_bit & ~strobe) | (hits[w] & in_delayed);
            end
        end

        assign prompt_q[w]  = p_bit;
        assign delayed_q[w] = d_bit;
    end

    // R4: outside both windows nothing may change
    assert_late_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (!strobe && win == WIN_NONE) |=>
            (prompt_q == $past(prompt_q) && delayed_q == $past(delayed_q)));

    // R3: past the prompt edge the prompt flags are frozen
    assert_prompt_closed_R3: assert property (@(posedge clk) disable iff (rst)
        (!strobe && win != WIN_PROMPT) |=> (prompt_q == $past(prompt_q)));

    // R5: flags are sticky inside a period
    assert_flags_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> (((prompt_q & $past(prompt_q)) == $past(prompt_q)) &&
                     ((delayed_q & $past(delayed_q)) == $past(delayed_q))));

    // R7: a strobe with no hits starts the period empty
    assert_strobe_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (strobe && hits == '0) |=> (prompt_q == '0 && delayed_q == '0));

endmodule

// File: rtl/dhc_word_reg.sv
module dhc_word_reg #(
    parameter int unsigned WORD_W = 2 * dhc_pkg::NUM_WIRES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic [WORD_W-1:0] flags,
    output logic [WORD_W-1:0] word_q,
    output logic              valid_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= strobe;
            if (strobe)
                word_q <= flags;
        end
    end

endmodule

// File: rtl/drift_hit_classifier.sv
module drift_hit_classifier
    import dhc_pkg::*;
#(
    parameter int unsigned NUM_WIRES = dhc_pkg::NUM_WIRES,
    parameter int unsigned TICK_W    = dhc_pkg::TICK_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   xing_strobe,
    input  logic [NUM_WIRES-1:0]   hit_in,
    input  logic [TICK_W-1:0]      prompt_end,
    input  logic [TICK_W-1:0]      delayed_end,
    output logic [2*NUM_WIRES-1:0] word_out,
    output logic                   word_valid
);

    localparam int unsigned WORD_W = 2 * NUM_WIRES;

    logic [TICK_W-1:0]    tick_now;
    win_t                 win_now;
    logic [NUM_WIRES-1:0] prompt_flags;
    logic [NUM_WIRES-1:0] delayed_flags;

    dhc_tick_counter #(.TICK_W(TICK_W)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .strobe   (xing_strobe),
        .tick_now (tick_now)
    );

    assign win_now = classify_tick(32'(tick_now), 32'(prompt_end), 32'(delayed_end));

    dhc_wire_flags #(.NUM_WIRES(NUM_WIRES)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .strobe    (xing_strobe),
        .hits      (hit_in),
        .win       (win_now),
        .prompt_q  (prompt_flags),
        .delayed_q (delayed_flags)
    );

    dhc_word_reg #(.WORD_W(WORD_W)) u_out (
        .clk     (clk),
        .rst     (rst),
        .strobe  (xing_strobe),
        .flags   ({delayed_flags, prompt_flags}),
        .word_q  (word_out),
        .valid_q (word_valid)
    );

    // R6: a valid pulse only ever follows a strobe
    assert_valid_after_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> $past(xing_strobe));

    // R8: the word holds while no pulse is present
    assert_word_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !word_valid |-> $stable(word_out));

endmodule

// File: tb/drift_hit_classifier_tb_top.sv
module drift_hit_classifier_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        xing_strobe = 1'b0;
    logic [11:0] hit_in = '0;
    logic [7:0]  prompt_end = 8'd22;
    logic [7:0]  delayed_end = 8'd70;
    logic [23:0] word_out;
    logic        word_valid;

    always #4 clk = ~clk;

    drift_hit_classifier dut_i (
        .clk         (clk),
        .rst         (rst),
        .xing_strobe (xing_strobe),
        .hit_in      (hit_in),
        .prompt_end  (prompt_end),
        .delayed_end (delayed_end),
        .word_out    (word_out),
        .word_valid  (word_valid)
    );

    int    vectors = 0;
    int    fails   = 0;
    int    cycles  = 0;
    bit    done    = 0;
    string cur_req = "R1";

    // behavioural reference
    int          m_tick  = 255;
    logic [11:0] m_p     = '0;
    logic [11:0] m_d     = '0;
    logic [23:0] e_word  = '0;
    logic        e_valid = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_tick = 255; m_p = '0; m_d = '0; e_word = '0; e_valid = 1'b0;
        end else begin
            if (xing_strobe) begin
                e_word = {m_d, m_p};
                m_p = '0; m_d = '0; m_tick = 0;
            end else if (m_tick < 255) begin
                m_tick++;
            end
            e_valid = xing_strobe;
            if (m_tick < int'(prompt_end))
                m_p = m_p | hit_in;
            else if (m_tick < int'(delayed_end))
                m_d = m_d | hit_in;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            vectors++;
            if (word_out !== e_word || word_valid !== e_valid) begin
                fails++;
                $display("FAIL %s cycle %0d: actual word=%h valid=%b expected word=%h valid=%b",
                         cur_req, cycles, word_out, word_valid, e_word, e_valid);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            fails++;
            $display("FAIL R6 watchdog: actual=still running expected=finished");
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    logic [11:0] sched [0:255];

    task automatic clear_sched();
        for (int i = 0; i < 256; i++) sched[i] = '0;
    endtask

    task automatic run_period(input int len);
        for (int c = 0; c < len; c++) begin
            @(negedge clk);
            xing_strobe = (c == 0);
            hit_in = sched[c];
        end
    endtask

    task automatic close_and_check(input logic [23:0] exp, input string req);
        @(negedge clk);
        xing_strobe = 1'b1; hit_in = '0;
        @(negedge clk);
        xing_strobe = 1'b0;
        vectors++;
        if (word_valid !== 1'b1 || word_out !== exp) begin
            fails++;
            $display("FAIL %s directed: actual word=%h valid=%b expected word=%h valid=1",
                     req, word_out, word_valid, exp);
        end
    endtask

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        vectors++;
        if (word_out !== '0 || word_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: actual word=%h valid=%b expected word=0 valid=0",
                     word_out, word_valid);
        end
        @(negedge clk); rst = 1'b0;

        // R4: hits before the first strobe are dropped
        cur_req = "R4";
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); hit_in = 12'hfff;
        end
        close_and_check(24'h000000, "R4");

        // R2 + R7: prompt hits, one in the strobe cycle itself
        cur_req = "R2";
        clear_sched(); sched[0] = 12'h001; sched[5] = 12'h008;
        run_period(44);
        close_and_check(24'h000009, "R2");

        // R3 + R4: boundary ticks and late hits on a long period
        cur_req = "R3";
        clear_sched();
        sched[21] = 12'h020; sched[22] = 12'h080; sched[69] = 12'h004;
        sched[70] = 12'h200; sched[85] = 12'h400;
        run_period(90);
        close_and_check(24'h084020, "R3");

        // R5: both flags on one wire
        cur_req = "R5";
        clear_sched(); sched[3] = 12'h001; sched[30] = 12'h001;
        run_period(44);
        close_and_check(24'h001001, "R5");

        // R9: reprogrammed edges 5 and 10
        cur_req = "R9";
        prompt_end = 8'd5; delayed_end = 8'd10;
        clear_sched();
        sched[4] = 12'h002; sched[5] = 12'h010; sched[9] = 12'h040; sched[10] = 12'h100;
        run_period(44);
        close_and_check(24'h050002, "R9");
        prompt_end = 8'd22; delayed_end = 8'd70;

        // R7: strobe-cycle hit belongs to the new period, not the closing one
        cur_req = "R7";
        clear_sched(); sched[0] = 12'h800;
        run_period(1);
        close_and_check(24'h000800, "R7");

        // R6: back-to-back strobes each give one pulse
        cur_req = "R6";
        clear_sched();
        run_period(1); run_period(1); run_period(1);
        @(negedge clk); xing_strobe = 1'b0; hit_in = '0;

        // R8: long randomized run compared every cycle
        cur_req = "R8";
        for (int p = 0; p < 300; p++) begin
            clear_sched();
            prompt_end  = 8'($urandom_range(0, 80));
            delayed_end = 8'($urandom_range(0, 120));
            begin
                int len;
                len = $urandom_range(1, 100);
                for (int c = 0; c < len; c++)
                    if ($urandom_range(0, 5) == 0) sched[c] = 12'($urandom);
                run_period(len);
            end
        end
        @(negedge clk); xing_strobe = 1'b0; hit_in = '0;
        repeat (3) @(negedge clk);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule